// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block computes and checks even parity for a multiplexed address/data bus that carries command or byte-enable lines alongside the data. A lower 32-bit lane has its own parity line, and an optional upper 32-bit lane, used only when a wide transfer has been agreed for the current transaction, has a second one. The count of ones across a lane's data, its command/byte-enable lines and its parity bit must always be even.

The parity line on the bus lags the values it covers by one clock. The block therefore registers the parity of each cycle's data and byte enables. When the bus interface drives the bus, that registered value is presented together with an output enable that is also delayed one clock, so parity drive starts and ends one cycle after data drive. When the bus interface receives an address or write data, the registered value is compared with the parity line sampled in the following cycle. A mismatch raises a one-clock error pulse and sets a sticky flag that stays set until a write-one clear.

For read data, the byte-enable lines seen by the block are the ones the initiator drives. The generated parity therefore combines the read data with the initiator's byte enables. The block only produces error pulses and flags. Reporting them on external error pins or status registers is handled elsewhere.

Top module: `bus_parity_unit`

## Requirements
- R1: In the cycle after a clock in which data `lo_ad` and enables `lo_cbe` are presented, `lo_par_out` equals the XOR of all 36 of those bits. This holds for address, write and read-data phases alike, and for read data the enables are the initiator's lines as seen on `lo_cbe`. Data, enables and `lo_par_out` together then hold an even number of ones.
- R2: With the upper lane present, `hi_par_out` follows the same rule one clock after `hi_ad` and `hi_cbe`.
- R3: `lo_par_oe` equals `drive_en` of the previous cycle. `hi_par_oe` equals `drive_en AND wide_xfer` of the previous cycle.
- R4: A check is armed in a cycle where (`addr_phase` OR `wdata_phase`) is 1 and `drive_en` is 0. If the parity line sampled in the next cycle differs from the parity computed for the armed cycle, the error pulse for that lane is 1 in the cycle after that, for exactly one cycle.
- R5: Read-data phases, idle cycles and cycles where the block drives the bus arm no check. A wrong parity line after such a cycle gives no pulse and leaves the sticky flag unchanged.
- R6: The upper-lane check is armed only when `wide_xfer` is 1 in the armed cycle. Otherwise a wrong `hi_par_in` is ignored.
- R7: A lane's sticky flag sets in the same cycle as its error pulse. It stays set until its clear input is 1 for a cycle, after which it reads 0. A new error in the cycle of a clear wins, and the flag stays 1.
- R8: While `rst_n` is 0, and in the cycle after it rises, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_ad | input | 32 | Lower-lane address/data as on the bus |
| lo_cbe | input | 4 | Lower command/byte-enable lines |
| hi_ad | input | 32 | Upper-lane data |
| hi_cbe | input | 4 | Upper byte-enable lines |
| addr_phase | input | 1 | Current cycle is an address phase |
| wdata_phase | input | 1 | Current cycle is a write data phase |
| rdata_phase | input | 1 | Current cycle is a read data phase |
| drive_en | input | 1 | This side drives address/data this cycle |
| wide_xfer | input | 1 | A 64-bit transfer has been agreed for the transaction |
| lo_par_in | input | 1 | Sampled lower parity line |
| hi_par_in | input | 1 | Sampled upper parity line |
| lo_err_clr | input | 1 | Write-one clear of the lower sticky flag |
| hi_err_clr | input | 1 | Write-one clear of the upper sticky flag |
| lo_par_out | output | 1 | Lower parity value to drive |
| hi_par_out | output | 1 | Upper parity value to drive |
| lo_par_oe | output | 1 | Lower parity output enable |
| hi_par_oe | output | 1 | Upper parity output enable |
| lo_err_pulse | output | 1 | One-clock lower parity error |
| hi_err_pulse | output | 1 | One-clock upper parity error |
| lo_err_flag | output | 1 | Sticky lower parity error |
| hi_err_flag | output | 1 | Sticky upper parity error |

## Verification
The bench builds the block with its defaults: 32-bit lanes, 4 enable bits each and the upper lane present (`HAS_UPPER = 1`). With the upper lane present, the gating of the second lane by `wide_xfer` can be observed, both for output enable and for error checking. Errors can also be provoked on both lanes in the same transfer or on one lane only, so the two sticky flags are seen to clear independently of each other.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    // Phase qualifiers of one bus cycle, grouped for internal use.
    typedef struct packed {
        logic addr;
        logic wdata;
        logic rdata;
    } phase_t;

    // A received address or write data is checked; driven or read cycles are not.
    function automatic logic arm_check(input phase_t ph, input logic driving);
        return (ph.addr | ph.wdata) & ~driving;
    endfunction

endpackage

// File: rtl/bpar_err_track.sv
// Turns a per-cycle mismatch into a one-clock registered pulse and a sticky flag.
// Assumes clr is a write-one pulse; a mismatch in the same cycle wins over clr.
module bpar_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic clr,
    output logic err_pulse,
    output logic err_flag
);

    // Register the pulse and update the sticky flag (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            err_pulse <= mismatch;
            err_flag  <= (err_flag & ~clr) | mismatch;
        end
    end

endmodule

// File: rtl/bpar_lane.sv
// One parity lane: even-parity reduction of data and enables, registered so it
// lines up with the lagging parity line; compares against the sampled line when
// the previous cycle armed a check. Assumes par_in is sampled one clock after data.
module bpar_lane #(
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data,
    input  logic [BW-1:0] be,
    input  logic          chk_en,
    input  logic          drv_en,
    input  logic          par_in,
    input  logic          clr,
    output logic          par_out,
    output logic          par_oe,
    output logic          err_pulse,
    output logic          err_flag
);

    localparam int CW = DW + BW;

    logic [CW-1:0] covered;
    logic          par_now;
    logic          chk_q;
    logic          mismatch;

    assign covered  = {data, be};
    assign par_now  = ^covered;

    // Delay parity, check arm and drive enable by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
            chk_q   <= 1'b0;
        end else begin
            par_out <= par_now;
            par_oe  <= drv_en;
            chk_q   <= chk_en;
        end
    end

    assign mismatch = chk_q & (par_out ^ par_in);

    bpar_err_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mismatch  (mismatch),
        .clr       (clr),
        .err_pulse (err_pulse),
        .err_flag  (err_flag)
    );

endmodule

// File: rtl/bus_parity_unit.sv
// Even-parity generator and checker for a multiplexed address/data bus with a
// lower lane and an optional upper lane. Assumes qualifiers describe the cycle
// in which data is valid and parity lines are sampled one clock later.
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int BE_W      = 4,
    parameter bit HAS_UPPER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lo_ad,
    input  logic [BE_W-1:0]   lo_cbe,
    input  logic [LANE_W-1:0] hi_ad,
    input  logic [BE_W-1:0]   hi_cbe,
    input  logic              addr_phase,
    input  logic              wdata_phase,
    input  logic              rdata_phase,
    input  logic              drive_en,
    input  logic              wide_xfer,
    input  logic              lo_par_in,
    input  logic              hi_par_in,
    input  logic              lo_err_clr,
    input  logic              hi_err_clr,
    output logic              lo_par_out,
    output logic              hi_par_out,
    output logic              lo_par_oe,
    output logic              hi_par_oe,
    output logic              lo_err_pulse,
    output logic              hi_err_pulse,
    output logic              lo_err_flag,
    output logic              hi_err_flag
);

    localparam int NLANE = HAS_UPPER ? 2 : 1;

    phase_t ph;
    logic   base_chk;

    logic [NLANE-1:0][LANE_W-1:0] l_data;
    logic [NLANE-1:0][BE_W-1:0]   l_be;
    logic [NLANE-1:0]             l_chk, l_drv, l_pin, l_clr;
    logic [NLANE-1:0]             l_par, l_oe, l_pulse, l_flag;

    assign ph       = '{addr: addr_phase, wdata: wdata_phase, rdata: rdata_phase};
    assign base_chk = arm_check(ph, drive_en);

    // Lower lane is always checked and driven on its own qualifiers.
    assign l_data[0] = lo_ad;
    assign l_be[0]   = lo_cbe;
    assign l_chk[0]  = base_chk;
    assign l_drv[0]  = drive_en;
    assign l_pin[0]  = lo_par_in;
    assign l_clr[0]  = lo_err_clr;

    generate
        if (HAS_UPPER) begin : g_upper
            // Upper lane participates only in agreed wide transfers.
            assign l_data[1] = hi_ad;
            assign l_be[1]   = hi_cbe;
            assign l_chk[1]  = base_chk & wide_xfer;
            assign l_drv[1]  = drive_en & wide_xfer;
            assign l_pin[1]  = hi_par_in;
            assign l_clr[1]  = hi_err_clr;
        end

        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            bpar_lane #(.DW(LANE_W), .BW(BE_W)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .data      (l_data[i]),
                .be        (l_be[i]),
                .chk_en    (l_chk[i]),
                .drv_en    (l_drv[i]),
                .par_in    (l_pin[i]),
                .clr       (l_clr[i]),
                .par_out   (l_par[i]),
                .par_oe    (l_oe[i]),
                .err_pulse (l_pulse[i]),
                .err_flag  (l_flag[i])
            );
        end

        if (HAS_UPPER) begin : g_hi_out
            assign hi_par_out   = l_par[1];
            assign hi_par_oe    = l_oe[1];
            assign hi_err_pulse = l_pulse[1];
            assign hi_err_flag  = l_flag[1];
        end else begin : g_hi_tie
            // No upper lane: its outputs stay low and its inputs are unused.
            logic unused_hi;
            assign unused_hi    = ^{hi_ad, hi_cbe, hi_par_in, hi_err_clr, wide_xfer};
            assign hi_par_out   = 1'b0;
            assign hi_par_oe    = 1'b0;
            assign hi_err_pulse = 1'b0;
            assign hi_err_flag  = 1'b0;
        end
    endgenerate

    assign lo_par_out   = l_par[0];
    assign lo_par_oe    = l_oe[0];
    assign lo_err_pulse = l_pulse[0];
    assign lo_err_flag  = l_flag[0];

endmodule

// File: rtl/bus_parity_unit_chk.sv
// Port-level temporal checks for bus_parity_unit, attached by bind below.
module bus_parity_unit_chk #(
    parameter int LANE_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LANE_W-1:0] lo_ad,
    input logic [BE_W-1:0]   lo_cbe,
    input logic              addr_phase,
    input logic              wdata_phase,
    input logic              drive_en,
    input logic              wide_xfer,
    input logic              lo_err_clr,
    input logic              hi_err_clr,
    input logic              lo_par_out,
    input logic              lo_par_oe,
    input logic              hi_par_oe,
    input logic              lo_err_pulse,
    input logic              hi_err_pulse,
    input logic              lo_err_flag,
    input logic              hi_err_flag
);

    logic pv1, pv2;

    // Track how many clean cycles have passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv1 <= 1'b0;
            pv2 <= 1'b0;
        end else begin
            pv1 <= 1'b1;
            pv2 <= pv1;
        end
    end

    a_r1_lo_par_lag: assert property (@(posedge clk) disable iff (!rst_n)
        pv1 |-> (lo_par_out == ^{$past(lo_ad), $past(lo_cbe)}));

    a_r3_lo_oe_lag: assert property (@(posedge clk) disable iff (!rst_n)
        pv1 |-> (lo_par_oe == $past(drive_en)));

    a_r3_hi_oe_lag: assert property (@(posedge clk) disable iff (!rst_n)
        pv1 |-> (hi_par_oe == ($past(drive_en) & $past(wide_xfer))));

    a_r5_no_pulse_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (pv2 && !(($past(addr_phase, 2) || $past(wdata_phase, 2)) && !$past(drive_en, 2)))
        |-> !lo_err_pulse);

    a_r6_hi_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (pv2 && !$past(wide_xfer, 2)) |-> !hi_err_pulse);

    a_r7_lo_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        lo_err_pulse |-> lo_err_flag);

    a_r7_lo_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(lo_err_flag) && !$past(lo_err_clr)) |-> lo_err_flag);

    a_r7_hi_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(hi_err_flag) && !$past(hi_err_clr)) |-> hi_err_flag);

endmodule

bind bus_parity_unit bus_parity_unit_chk #(.LANE_W(LANE_W), .BE_W(BE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_ad        (lo_ad),
    .lo_cbe       (lo_cbe),
    .addr_phase   (addr_phase),
    .wdata_phase  (wdata_phase),
    .drive_en     (drive_en),
    .wide_xfer    (wide_xfer),
    .lo_err_clr   (lo_err_clr),
    .hi_err_clr   (hi_err_clr),
    .lo_par_out   (lo_par_out),
    .lo_par_oe    (lo_par_oe),
    .hi_par_oe    (hi_par_oe),
    .lo_err_pulse (lo_err_pulse),
    .hi_err_pulse (hi_err_pulse),
    .lo_err_flag  (lo_err_flag),
    .hi_err_flag  (hi_err_flag)
);

// File: tb/bus_parity_unit_tb.sv
module bus_parity_unit_tb;

    typedef struct packed {
        logic [31:0] lad;
        logic [3:0]  lcbe;
        logic [31:0] had;
        logic [3:0]  hcbe;
        logic        ap;
        logic        wp;
        logic        rp;
        logic        drv;
        logic        wide;
        logic        flo;
        logic        fhi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0000_0001, 4'h6, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 4'h7, 32'h0000_00FF, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{32'h1234_5678, 4'h0, 32'hDEAD_BEEF, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{32'hA5A5_0F0F, 4'hC, 32'h0000_0001, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{32'h8000_0003, 4'h2, 32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'hCAFE_0001, 4'hA, 32'h7777_0000, 4'h5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0F00_0000, 4'hF, 32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_1111, 4'h8, 32'h1000_0001, 4'hE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lo_ad = '0, hi_ad = '0;
    logic [3:0]  lo_cbe = '0, hi_cbe = '0;
    logic        addr_phase = 0, wdata_phase = 0, rdata_phase = 0;
    logic        drive_en = 0, wide_xfer = 0;
    logic        lo_par_in = 0, hi_par_in = 0, lo_err_clr = 0, hi_err_clr = 0;
    logic        lo_par_out, hi_par_out, lo_par_oe, hi_par_oe;
    logic        lo_err_pulse, hi_err_pulse, lo_err_flag, hi_err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .lo_ad(lo_ad), .lo_cbe(lo_cbe), .hi_ad(hi_ad), .hi_cbe(hi_cbe),
        .addr_phase(addr_phase), .wdata_phase(wdata_phase), .rdata_phase(rdata_phase),
        .drive_en(drive_en), .wide_xfer(wide_xfer),
        .lo_par_in(lo_par_in), .hi_par_in(hi_par_in),
        .lo_err_clr(lo_err_clr), .hi_err_clr(hi_err_clr),
        .lo_par_out(lo_par_out), .hi_par_out(hi_par_out),
        .lo_par_oe(lo_par_oe), .hi_par_oe(hi_par_oe),
        .lo_err_pulse(lo_err_pulse), .hi_err_pulse(hi_err_pulse),
        .lo_err_flag(lo_err_flag), .hi_err_flag(hi_err_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lo_ad = '0; lo_cbe = '0; hi_ad = '0; hi_cbe = '0;
        addr_phase = 0; wdata_phase = 0; rdata_phase = 0;
        drive_en = 0; wide_xfer = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic st_lo, st_hi, elo, ehi, arm;
        st_lo = 0; st_hi = 0;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "lo_par_oe in reset", lo_par_oe, 1'b0);
        check("R8", "lo_err_flag in reset", lo_err_flag, 1'b0);
        check("R8", "hi_err_flag in reset", hi_err_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "lo_par_out after reset", lo_par_out, 1'b0);
        check("R8", "hi_err_pulse after reset", hi_err_pulse, 1'b0);

        // Table walk: R1..R7
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            lo_par_in = 0; hi_par_in = 0;
            lo_ad = v.lad; lo_cbe = v.lcbe; hi_ad = v.had; hi_cbe = v.hcbe;
            addr_phase = v.ap; wdata_phase = v.wp; rdata_phase = v.rp;
            drive_en = v.drv; wide_xfer = v.wide;
            @(negedge clk);
            check("R1", $sformatf("v%0d lo_par_out", i), lo_par_out, ^{v.lad, v.lcbe});
            check("R2", $sformatf("v%0d hi_par_out", i), hi_par_out, ^{v.had, v.hcbe});
            check("R3", $sformatf("v%0d lo_par_oe", i), lo_par_oe, v.drv);
            check("R3", $sformatf("v%0d hi_par_oe", i), hi_par_oe, v.drv & v.wide);
            lo_par_in = (^{v.lad, v.lcbe}) ^ v.flo;
            hi_par_in = (^{v.had, v.hcbe}) ^ v.fhi;
            idle_inputs();
            arm = (v.ap | v.wp) & ~v.drv;
            elo = arm & v.flo;
            ehi = arm & v.wide & v.fhi;
            st_lo |= elo; st_hi |= ehi;
            @(negedge clk);
            check(elo ? "R4" : "R5", $sformatf("v%0d lo_err_pulse", i), lo_err_pulse, elo);
            check(ehi ? "R4" : "R6", $sformatf("v%0d hi_err_pulse", i), hi_err_pulse, ehi);
            check("R7", $sformatf("v%0d lo_err_flag", i), lo_err_flag, st_lo);
            check("R7", $sformatf("v%0d hi_err_flag", i), hi_err_flag, st_hi);
        end

        // R4: pulse lasts one cycle only
        lo_par_in = 0; hi_par_in = 0;
        @(negedge clk);
        check("R4", "lo pulse single cycle", lo_err_pulse, 1'b0);
        check("R4", "hi pulse single cycle", hi_err_pulse, 1'b0);

        // R7: write-one clear, lanes independent
        lo_err_clr = 1;
        @(negedge clk);
        lo_err_clr = 0;
        check("R7", "lo flag cleared", lo_err_flag, 1'b0);
        check("R7", "hi flag kept", hi_err_flag, 1'b1);
        hi_err_clr = 1;
        @(negedge clk);
        hi_err_clr = 0;
        check("R7", "hi flag cleared", hi_err_flag, 1'b0);
        @(negedge clk);
        check("R7", "lo flag stays clear", lo_err_flag, 1'b0);

        // R7: error in the cycle of a clear wins
        wdata_phase = 1; lo_ad = 32'h0000_0003; lo_cbe = 4'h0;
        @(negedge clk);
        idle_inputs();
        lo_par_in = 1'b1;
        lo_err_clr = 1;
        @(negedge clk);
        lo_err_clr = 0; lo_par_in = 0;
        check("R7", "set wins over clear", lo_err_flag, 1'b1);
        check("R4", "pulse with clear", lo_err_pulse, 1'b1);

        // R8: reset mid-run clears flag
        rst_n = 0;
        @(negedge clk);
        check("R8", "mid-run reset flag", lo_err_flag, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R8", "after reset oe", lo_par_oe, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule